// File: doc/BRIEF.md
# SPI Register Target with CRC-8 Frame Protection

This block is the device side of an SPI link. Through it a host reads and writes a small bank of 16-bit registers, each selected by a 7-bit address. The link runs in SPI mode 0 and sends 8-bit bytes. A frame lasts from the falling edge of chip select to its rising edge. The first byte of every frame is a command byte, which holds the address and the transfer direction. A 16-bit payload follows it, high byte first.

Frame protection can be switched on at run time by setting a bit in the configuration register. From the next frame on, each frame carries one more byte: a CRC-8 computed over the command byte and the two payload bytes. A write whose CRC does not match is thrown away, and a sticky error flag is raised. That flag can drive an active-high interrupt output, subject to an enable bit. The register bank also holds a read-only identity word, made up of a product code and a revision.

The SPI pins are sampled by a faster system clock through synchronizers. The serial clock must therefore be slow enough that each half period lasts several system clock cycles.

Top module: `spireg_crc8`

## Requirements
- R1: After reset, the identity register 0x00 reads {PROD_ID, REV_ID}, and the configuration (0x03), status (0x08) and enable (0x09) registers read 0x0000. `irq` is low.
- R2: Bits 7:1 of the command byte carry the register address, and bit 0 carries the direction: 1 for read, 0 for write. Every byte is sent MSB first, and the payload is sent high byte first.
- R3: With protection off, a write frame is 3 bytes (command, data high, data low). It loads the full 16-bit value into register 0x03 or 0x09.
- R4: In a read frame, MISO carries the register's high byte in the byte slot after the command and its low byte in the slot after that.
- R5: Register 0x00 is read-only. A write to it leaves its value unchanged.
- R6: The CRC is CRC-8 with polynomial 0x31, processed LSB first (reflected constant 0x8C), with initial value 0x00. It is computed over the command byte, the high byte and the low byte, in that order. With protection on, a read frame returns this CRC, computed over the returned data, in a fourth slot.
- R7: Bit 1 of register 0x03 turns protection on. The frame that sets the bit is sent without a CRC. The new mode applies from the following frame onward, and the mode stays fixed for the whole of a frame.
- R8: With protection on, a write frame is 4 bytes. If the fourth byte matches the CRC, the register is written. If it does not match, no register changes and bit 1 of status register 0x08 is set.
- R9: The status CRC-error bit stays set until a read frame of 0x08 completes. That read returns the bit set, and the bit then clears.
- R10: `irq` is high exactly when status bit 1 and enable bit 1 (register 0x09) are both set.
- R11: A frame in which chip select rises before all of its bytes have arrived changes no register and does not set the error flag.
- R12: Writes to unmapped addresses and to register 0x08 have no effect, and unmapped addresses read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| cs_n | input | 1 | SPI chip select, active low; frames one transfer |
| mosi | input | 1 | Host-to-device serial data, sampled on rising sclk |
| miso | output | 1 | Device-to-host serial data, changed after falling sclk |
| irq | output | 1 | Active-high interrupt: CRC-error flag gated by its enable |

## Verification
The hardest state to reach is a CRC mismatch on a write. It requires protection to have been switched on by an earlier unprotected frame, followed by a 4-byte write carrying a deliberately corrupted CRC. The bench first enables protection with a 3-byte write. It then mixes random reads and writes in which about one write in four has its CRC byte flipped. A reference model tracks the mode, the flag and the enable, so each flag read and each level of `irq` can be predicted. Chip-select aborts are driven as directed cases in both modes, each followed by a read-back of the register the aborted frame targeted.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam int SLOT_W = 3;
  localparam logic [BYTE_W-1:0] CRC_POLY_REFL = 8'h8C;
  localparam logic [ADDR_W-1:0] A_ID  = 7'h00;
  localparam logic [ADDR_W-1:0] A_CFG = 7'h03;
  localparam logic [ADDR_W-1:0] A_STS = 7'h08;
  localparam logic [ADDR_W-1:0] A_EN  = 7'h09;
  localparam int CFG_CRC_BIT = 1;
  localparam int STS_CRC_BIT = 1;

  function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] crc_in,
                                                  input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] c;
    c = crc_in;
    for (int i = 0; i < BYTE_W; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [BYTE_W-1:0] crc8_frame(input logic [BYTE_W-1:0] cmd,
                                                   input logic [DATA_W-1:0] data);
    logic [BYTE_W-1:0] c;
    c = crc8_step(8'h00, cmd);
    c = crc8_step(c, data[15:8]);
    c = crc8_step(c, data[7:0]);
    return c;
  endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_in;
    if (s == 0) begin : g_first
      assign stg_in = d;
    end else begin : g_next
      assign stg_in = stg[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else        stg[s] <= stg_in;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spireg_shift.sv
module spireg_shift
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] load_data,
  output logic              frame_start,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  logic              sclk_q, cs_q;
  logic [2:0]        bit_q, bit_nx;
  logic [BYTE_W-2:0] rx_q, rx_nx;
  logic [BYTE_W-1:0] tx_q, tx_nx;
  logic              rise, fall;

  assign rise        = sclk_s & ~sclk_q & ~cs_s;
  assign fall        = ~sclk_s & sclk_q & ~cs_s;
  assign frame_start = cs_q & ~cs_s;
  assign byte_done   = rise & (bit_q == 3'd7);
  assign rx_byte     = {rx_q, mosi_s};
  assign miso        = tx_q[BYTE_W-1];

  always_comb begin
    bit_nx = bit_q;
    rx_nx  = rx_q;
    tx_nx  = tx_q;
    if (cs_s || frame_start) begin
      bit_nx = '0;
      if (frame_start) tx_nx = '0;
    end else if (rise) begin
      bit_nx = bit_q + 3'd1;
      rx_nx  = rx_byte[BYTE_W-2:0];
      if (byte_done) tx_nx = load_data;
    end else if (fall && bit_q != 3'd0) begin
      tx_nx = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
      bit_q  <= bit_nx;
      rx_q   <= rx_nx;
      tx_q   <= tx_nx;
    end
  end
endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
  import spireg_pkg::*;
#(
  parameter logic [7:0] PROD_ID = 8'hA7,
  parameter logic [7:0] REV_ID  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              err_set,
  input  logic              rd_clr,
  output logic              crc_en,
  output logic              sts_flag,
  output logic              irq
);
  logic [DATA_W-1:0] cfg_q, cfg_nx, en_q, en_nx;
  logic              sts_q, sts_nx;

  always_comb begin
    cfg_nx = cfg_q;
    en_nx  = en_q;
    sts_nx = sts_q;
    if (wr_en && wr_addr == A_CFG) cfg_nx = wr_data;
    if (wr_en && wr_addr == A_EN)  en_nx  = wr_data;
    if (err_set)     sts_nx = 1'b1;
    else if (rd_clr) sts_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= '0;
      sts_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nx;
      en_q  <= en_nx;
      sts_q <= sts_nx;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_ID:    rd_data = {PROD_ID, REV_ID};
      A_CFG:   rd_data = cfg_q;
      A_STS:   rd_data[STS_CRC_BIT] = sts_q;
      A_EN:    rd_data = en_q;
      default: rd_data = '0;
    endcase
  end

  assign crc_en   = cfg_q[CFG_CRC_BIT];
  assign sts_flag = sts_q;
  assign irq      = sts_q & en_q[STS_CRC_BIT];
endmodule

// File: rtl/spireg_crc8.sv
module spireg_crc8
  import spireg_pkg::*;
#(
  parameter logic [7:0] PROD_ID = 8'hA7,
  parameter logic [7:0] REV_ID  = 8'h02,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic irq
);
  logic              sclk_s, cs_s, mosi_s;
  logic              frame_start, byte_done;
  logic [BYTE_W-1:0] rx_byte, load_data;
  logic [SLOT_W-1:0] slot_q, slot_nx;
  logic              crc_mode, crc_mode_nx, crc_en, sts_flag;
  logic [BYTE_W-1:0] cmd_q, cmd_nx, hi_q, hi_nx, lo_q, lo_nx;
  logic [DATA_W-1:0] rdbuf_q, rdbuf_nx, rd_data, wr_data;
  logic              wr_en, err_set, rd_clr, crc_ok, is_rd;
  logic [SLOT_W-1:0] last_slot;

  spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q({sclk_s, cs_s, mosi_s})
  );

  spireg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s(cs_s), .mosi_s(mosi_s),
    .load_data(load_data), .frame_start(frame_start), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(miso)
  );

  spireg_bank #(.PROD_ID(PROD_ID), .REV_ID(REV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cmd_q[7:1]), .wr_data(wr_data),
    .rd_addr(rx_byte[7:1]), .rd_data(rd_data), .err_set(err_set), .rd_clr(rd_clr),
    .crc_en(crc_en), .sts_flag(sts_flag), .irq(irq)
  );

  assign is_rd     = cmd_q[0];
  assign last_slot = crc_mode ? SLOT_W'(3) : SLOT_W'(2);
  assign crc_ok    = (crc8_frame(cmd_q, {hi_q, lo_q}) == rx_byte);
  assign wr_data   = crc_mode ? {hi_q, lo_q} : {hi_q, rx_byte};

  always_comb begin
    wr_en   = 1'b0;
    err_set = 1'b0;
    rd_clr  = 1'b0;
    if (byte_done && slot_q != 3'd0) begin
      if (!is_rd && !crc_mode && slot_q == 3'd2) wr_en = 1'b1;
      if (!is_rd && crc_mode && slot_q == 3'd3) begin
        wr_en   = crc_ok;
        err_set = ~crc_ok;
      end
      if (is_rd && slot_q == last_slot && cmd_q[7:1] == A_STS) rd_clr = 1'b1;
    end
  end

  always_comb begin
    load_data = '0;
    case (slot_q)
      3'd0:    load_data = rx_byte[0] ? rd_data[15:8] : '0;
      3'd1:    load_data = is_rd ? rdbuf_q[7:0] : '0;
      3'd2:    load_data = (is_rd && crc_mode) ? crc8_frame(cmd_q, rdbuf_q) : '0;
      default: load_data = '0;
    endcase
  end

  always_comb begin
    slot_nx     = slot_q;
    crc_mode_nx = crc_mode;
    cmd_nx      = cmd_q;
    hi_nx       = hi_q;
    lo_nx       = lo_q;
    rdbuf_nx    = rdbuf_q;
    if (frame_start) begin
      slot_nx     = '0;
      crc_mode_nx = crc_en;
    end else if (byte_done) begin
      if (slot_q != 3'd4) slot_nx = slot_q + 3'd1;
      case (slot_q)
        3'd0: begin
          cmd_nx   = rx_byte;
          rdbuf_nx = rd_data;
        end
        3'd1:    hi_nx = rx_byte;
        3'd2:    lo_nx = rx_byte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= 3'd4;
      crc_mode <= 1'b0;
      cmd_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      rdbuf_q  <= '0;
    end else begin
      slot_q   <= slot_nx;
      crc_mode <= crc_mode_nx;
      cmd_q    <= cmd_nx;
      hi_q     <= hi_nx;
      lo_q     <= lo_nx;
      rdbuf_q  <= rdbuf_nx;
    end
  end
endmodule

// File: rtl/spireg_crc8_chk.sv
module spireg_crc8_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic err_set,
  input logic rd_clr,
  input logic sts_flag,
  input logic irq,
  input logic crc_mode,
  input logic frame_start
);
  AST_MODE_FIXED_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(crc_mode)); // R7

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3

  AST_MISMATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> !wr_en); // R8

  AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> sts_flag); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flag && !rd_clr) |=> sts_flag); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_flag); // R10
endmodule

bind spireg_crc8 spireg_crc8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .err_set(err_set), .rd_clr(rd_clr),
  .sts_flag(sts_flag), .irq(irq), .crc_mode(crc_mode), .frame_start(frame_start)
);

// File: tb/spireg_crc8_test.sv
`timescale 1ns/1ps
module spireg_crc8_test;
  localparam logic [7:0] PID = 8'hA7;
  localparam logic [7:0] RID = 8'h02;
  localparam time HALF = 80ns;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq;
  int checks = 0, errors = 0;

  logic [15:0] m_cfg, m_en;
  logic        m_sts;

  always #5ns clk = ~clk;

  spireg_crc8 #(.PROD_ID(PID), .REV_ID(RID)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .irq(irq)
  );

  function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] c);
    logic [23:0] s;
    logic [7:0]  r;
    s = {c, b, a};
    r = 8'h00;
    for (int i = 0; i < 24; i++) begin
      r = {1'b0, r[7:1]} ^ ((r[0] ^ s[i]) ? 8'h8C : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_read(input logic [6:0] a);
    case (a)
      7'h00:   return {PID, RID};
      7'h03:   return m_cfg;
      7'h08:   return {14'd0, m_sts, 1'b0};
      7'h09:   return m_en;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tb0, input logic [7:0] tb1, input logic [7:0] tb2,
                      input logic [7:0] tb3, input int n, output logic [31:0] rb);
    logic [31:0] tw;
    tw = {tb0, tb1, tb2, tb3};
    rb = '0;
    @(negedge clk);
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = tw[31 - 8*i - (7 - b)];
        #(HALF);
        rb[31 - 8*i - (7 - b)] = miso;
        sclk = 1'b1;
        #(HALF);
        sclk = 1'b0;
      end
    end
    #(HALF);
    cs_n = 1'b1;
    mosi = 1'b0;
    #(HALF*3);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d, input bit bad,
                          input string tag);
    logic [7:0]  cmd, c;
    logic [31:0] rb;
    bit          prot;
    prot = m_cfg[1];
    cmd  = {a, 1'b0};
    c    = ref_crc(cmd, d[15:8], d[7:0]) ^ (bad ? 8'h01 : 8'h00);
    xfer(cmd, d[15:8], d[7:0], c, prot ? 4 : 3, rb);
    if (prot && bad) m_sts = 1'b1;
    else if (a == 7'h03) m_cfg = d;
    else if (a == 7'h09) m_en = d;
    check({tag, " R10 irq"}, {15'd0, irq}, {15'd0, m_sts & m_en[1]});
  endtask

  task automatic do_read(input logic [6:0] a, input string tag);
    logic [7:0]  cmd;
    logic [15:0] e;
    logic [31:0] rb;
    bit          prot;
    prot = m_cfg[1];
    cmd  = {a, 1'b1};
    e    = exp_read(a);
    xfer(cmd, 8'h00, 8'h00, 8'h00, prot ? 4 : 3, rb);
    check({tag, " R4 data"}, rb[23:8], e);
    if (prot) check({tag, " R6 crc"}, {8'h00, rb[7:0]}, {8'h00, ref_crc(cmd, e[15:8], e[7:0])});
    if (a == 7'h08) m_sts = 1'b0;
    check({tag, " R10 irq"}, {15'd0, irq}, {15'd0, m_sts & m_en[1]});
  endtask

  initial begin
    #1500us;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    void'($urandom(32'd1234));
    m_cfg = '0; m_en = '0; m_sts = 1'b0;
    #100ns;
    rst_n = 1'b1;
    #50ns;
    check("R1 irq reset", {15'd0, irq}, 16'd0);
    check("R1 miso reset", {15'd0, miso}, 16'd0);
    do_read(7'h00, "R1 id");
    do_read(7'h03, "R1 cfg");
    do_read(7'h08, "R1 sts");
    do_read(7'h09, "R1 en");
    // R2 R3: 3-byte writes, high byte first
    do_write(7'h09, 16'h8002, 0, "R3 en");
    do_read(7'h09, "R3 en rb");
    do_write(7'h03, 16'h5C01, 0, "R3 cfg");
    do_read(7'h03, "R2 cfg rb");
    // R5 read-only identity
    do_write(7'h00, 16'h1234, 0, "R5");
    do_read(7'h00, "R5 id rb");
    // R12 unmapped and status writes
    do_write(7'h21, 16'hFFFF, 0, "R12");
    do_read(7'h21, "R12 unmapped");
    do_write(7'h08, 16'hFFFF, 0, "R12 sts");
    do_read(7'h08, "R12 sts rb");
    // R11 abort in unprotected mode
    xfer(8'h12, 8'hAB, 8'h00, 8'h00, 2, rb);
    do_read(7'h09, "R11 abort off");
    // R7 enable protection with an unprotected frame
    do_write(7'h03, 16'h0002, 0, "R7 on");
    do_read(7'h03, "R7 cfg crc");
    do_write(7'h09, 16'h0002, 0, "R8 good");
    do_read(7'h09, "R8 good rb");
    // R8 mismatch
    do_write(7'h09, 16'h0000, 1, "R8 bad");
    do_read(7'h09, "R8 bad no write");
    check("R10 irq set", {15'd0, irq}, 16'd1);
    // R11 abort in protected mode: 3 bytes only
    xfer(8'h12, 8'h00, 8'h00, 8'h00, 3, rb);
    do_read(7'h09, "R11 abort on");
    // R9 read clears
    do_read(7'h08, "R9 sts set");
    do_read(7'h08, "R9 sts clr");
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [6:0]  a;
      logic [15:0] d;
      int          sel;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 7'h00;
        1: a = 7'h03;
        2: a = 7'h08;
        3: a = 7'h09;
        default: a = 7'($urandom_range(0, 127));
      endcase
      d = 16'($urandom);
      if (a == 7'h03 && $urandom_range(0, 1) == 0) d[1] = 1'b1;
      if ($urandom_range(0, 1) == 0) do_write(a, d, $urandom_range(0, 3) == 0, "R8 rnd wr");
      else                           do_read(a, "R6 rnd rd");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule